// File: doc/BRIEF.md
# Speculative Load Snoop Violation Detector

This block keeps a small circular queue of loads that have been dispatched but not yet retired. Each entry records the cache line that the load reads and whether the load has already performed its read. A load that has read memory but has not committed holds a value that another processor may have overwritten since. The block watches a snoop port that carries writes from other processors. When such a write lands in the line of any speculative load that has already read, the block asks the core for a full pipeline flush.

A pause input lets software-visible spin-wait code serialize its loads. While pause is held, no new load is dispatched until every older queued load has committed. This shrinks the window between a load's read and its commit to one load at a time.

The core allocates loads at the tail and receives the slot index. It marks a slot as executed when the read is done and commits loads from the head in program order. The block clears itself one cycle after it raises a flush.

Top module: `lq_snoop_guard`

## Requirements
- R1: After synchronous reset the queue is empty: `flush`, `full`, `alloc_gnt` and `dispatch_stall` are 0 (also with `pause`=1) and `alloc_idx` is 0.
- R2: A request with `alloc_req`=1 is granted (`alloc_gnt`=1 in the same cycle) when the queue is not full and dispatch is not stalled. `alloc_idx` shows the slot that the grant fills. Slots are handed out in order 0,1,2,… and wrap to 0 after DEPTH-1.
- R3: When all DEPTH (default 8) slots hold loads, `full`=1 and an allocation request is refused (`alloc_gnt`=0).
- R4: A snoop write whose line (address bits [ADDR_W-1:6] for the default 64-byte line, offset ignored) equals that of a queued, executed, uncommitted load makes `flush` 1 in the next cycle only. A snoop that arrives in the flush cycle is ignored.
- R5: A snoop causes no flush if the matching load is allocated but not yet executed, or if no queued load is in the snooped line.
- R6: A load that is marked executed in the same cycle as a snoop to its line counts as a violation and causes a flush.
- R7: Committed loads are never matched. This includes a load that commits in the same cycle as the snoop.
- R8: `commit_req` retires the head slot only if that load has executed. Otherwise it has no effect and the queue stays non-empty.
- R9: In the cycle `flush`=1, allocation, execute, commit and snoop inputs are ignored and `alloc_gnt`=0. At the end of that cycle every slot is cleared and both pointers return to 0.
- R10: `dispatch_stall` = `flush` OR (`pause` AND queue not empty). While it is 1, no allocation is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request to queue a new load |
| alloc_addr | input | ADDR_W | Address the new load will read |
| alloc_gnt | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | IDX_W | Slot index given to the allocated load (current tail) |
| exec_req | input | 1 | A queued load has read memory |
| exec_idx | input | IDX_W | Slot of the load that has read |
| commit_req | input | 1 | Retire the oldest load |
| snoop_valid | input | 1 | External write observed |
| snoop_addr | input | ADDR_W | Address of the external write |
| pause | input | 1 | Serialize dispatch until the queue drains |
| flush | output | 1 | One-cycle pipeline flush request |
| dispatch_stall | output | 1 | New loads may not be dispatched |
| full | output | 1 | All slots occupied |

## Verification
The hardest cases to reach are the same-cycle collisions. A snoop can arrive exactly as its target load executes, exactly as that load commits, or during the flush cycle itself. The stimulus table schedules execute, commit and snoop on the same cycle to hit each of these. It follows each one with pause-mode allocations, so that the queue occupancy after a refused commit shows up on `dispatch_stall`. A directed fill wraps the tail pointer. It then retires one load and reallocates that slot, and finally flushes the full queue.

// File: rtl/lq_snoop_pkg.sv
package lq_snoop_pkg;

    // Per-slot bookkeeping bits
    typedef struct packed {
        logic valid;   // slot holds a queued load
        logic done;    // load has read memory
    } lq_flags_t;

    // Qualified per-cycle operations seen by the slot array
    typedef struct packed {
        logic alloc;
        logic exec;
        logic retire;
        logic snoop;
        logic clear;
    } lq_ops_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lq_ptr_ctrl.sv
module lq_ptr_ctrl #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= bump(tail);
            if (pop)  head <= bump(head);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)) else $error("count overflow"); // R3

    AST_NO_UNDERFLOW_POP: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty) else $error("pop on empty"); // R8

endmodule

// File: rtl/lq_slot_array.sv
module lq_slot_array
    import lq_snoop_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  lq_ops_t          ops,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [IDX_W-1:0] exec_idx,
    input  logic [IDX_W-1:0] retire_idx,
    input  logic [TAG_W-1:0] snoop_tag,
    output logic [DEPTH-1:0] valid_vec,
    output logic [DEPTH-1:0] done_vec,
    output logic             hit
);

    logic [DEPTH-1:0] hit_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        lq_flags_t        fl_q;
        logic [TAG_W-1:0] tag_q;
        logic             sel_alloc;
        logic             sel_exec;
        logic             sel_retire;

        assign sel_alloc  = ops.alloc  && (alloc_idx  == IDX_W'(i));
        assign sel_exec   = ops.exec   && (exec_idx   == IDX_W'(i)) && fl_q.valid;
        assign sel_retire = ops.retire && (retire_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst || ops.clear) begin
                fl_q <= '0;
            end else begin
                if (sel_retire) fl_q.valid <= 1'b0;
                if (sel_exec)   fl_q.done  <= 1'b1;
                if (sel_alloc) begin
                    fl_q  <= '{valid: 1'b1, done: 1'b0};
                    tag_q <= alloc_tag;
                end
            end
        end

        // A read already done (or done this cycle) by a load that is not retiring now
        assign hit_vec[i] = ops.snoop && fl_q.valid
                          && (fl_q.done || sel_exec)
                          && !sel_retire
                          && (tag_q == snoop_tag);

        assign valid_vec[i] = fl_q.valid;
        assign done_vec[i]  = fl_q.done;

        AST_RETIRE_EXECUTED: assert property (@(posedge clk) disable iff (rst)
            sel_retire |-> (fl_q.valid && fl_q.done)) else $error("retire of unexecuted slot"); // R8

        AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
            sel_alloc |-> !fl_q.valid) else $error("allocation over live slot"); // R2
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/lq_flush_pulse.sv
module lq_flush_pulse (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic flush
);

    always_ff @(posedge clk) begin
        if (rst) flush <= 1'b0;
        else     flush <= hit;
    end

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush) else $error("flush longer than one cycle"); // R4

endmodule

// File: rtl/lq_snoop_guard.sv
module lq_snoop_guard
    import lq_snoop_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 6,
    localparam int IDX_W = idx_width(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int TAG_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic              alloc_gnt,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              exec_req,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic              commit_req,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              pause,
    output logic              flush,
    output logic              dispatch_stall,
    output logic              full
);

    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    logic             empty;
    logic [DEPTH-1:0] valid_vec, done_vec;
    logic             hit;
    lq_ops_t          ops;

    logic unused_offsets;
    assign unused_offsets = ^{alloc_addr[OFS_W-1:0], snoop_addr[OFS_W-1:0]};

    // Dispatch gating: flush cycle or pause with older loads outstanding
    assign dispatch_stall = flush || (pause && !empty);
    assign alloc_gnt      = alloc_req && !full && !dispatch_stall;
    assign alloc_idx      = tail;

    always_comb begin
        ops        = '0;
        ops.clear  = flush;
        ops.alloc  = alloc_gnt;
        ops.exec   = exec_req    && !flush;
        ops.retire = commit_req  && !flush && valid_vec[head] && done_vec[head];
        ops.snoop  = snoop_valid && !flush;
    end

    lq_ptr_ctrl #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .clear (ops.clear),
        .push  (ops.alloc),
        .pop   (ops.retire),
        .head  (head),
        .tail  (tail),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    lq_slot_array #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_slots (
        .clk        (clk),
        .rst        (rst),
        .ops        (ops),
        .alloc_idx  (tail),
        .alloc_tag  (alloc_addr[ADDR_W-1:OFS_W]),
        .exec_idx   (exec_idx),
        .retire_idx (head),
        .snoop_tag  (snoop_addr[ADDR_W-1:OFS_W]),
        .valid_vec  (valid_vec),
        .done_vec   (done_vec),
        .hit        (hit)
    );

    lq_flush_pulse u_flush (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .flush (flush)
    );

    AST_OCCUPANCY_MATCH: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_vec) == int'(count)) else $error("slot/pointer mismatch"); // R2

    AST_FLUSH_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (rst)
        flush |-> $past(snoop_valid)) else $error("flush without snoop"); // R4

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && valid_vec == '0)) else $error("queue not cleared"); // R9

    AST_PAUSE_SERIAL: assert property (@(posedge clk) disable iff (rst)
        (pause && alloc_gnt) |-> (valid_vec == '0)) else $error("paused dispatch with older loads"); // R10

endmodule

// File: tb/lq_snoop_guard_test.sv
module lq_snoop_guard_test;

    typedef struct packed {
        logic       al;
        logic [3:0] aline;
        logic       ex;
        logic [2:0] eidx;
        logic       cm;
        logic       sn;
        logic [3:0] sline;
        logic       pz;
        logic       e_gnt;
        logic [2:0] e_idx;
        logic       e_stall;
        logic       e_full;
        logic       e_flush;   // expected flush in the following cycle
        logic [3:0] rid;
    } vec_t;

    function automatic vec_t mk(input logic al, input logic [3:0] aline,
                                input logic ex, input logic [2:0] eidx,
                                input logic cm, input logic sn,
                                input logic [3:0] sline, input logic pz,
                                input logic g, input logic [2:0] ix,
                                input logic st, input logic fu,
                                input logic fl, input logic [3:0] rid);
        return '{al, aline, ex, eidx, cm, sn, sline, pz, g, ix, st, fu, fl, rid};
    endfunction

    localparam int NV = 19;
    //                  al ln ex ix cm sn ln pz | gnt idx stl ful fl  req
    localparam vec_t TBL [NV] = '{
        mk(1, 1, 0, 0, 0, 0, 0, 0,  1, 0, 0, 0, 0,  2),  // R2 first slot
        mk(0, 0, 0, 0, 0, 1, 1, 0,  0, 1, 0, 0, 0,  5),  // R5 not executed
        mk(0, 0, 1, 0, 0, 0, 0, 0,  0, 1, 0, 0, 0,  2),
        mk(0, 0, 0, 0, 0, 1, 2, 0,  0, 1, 0, 0, 0,  5),  // R5 other line
        mk(1, 2, 0, 0, 0, 0, 0, 0,  1, 1, 0, 0, 0,  2),  // R2 second slot
        mk(0, 0, 0, 0, 1, 0, 0, 0,  0, 2, 0, 0, 0,  8),  // R8 commit executed head
        mk(0, 0, 0, 0, 0, 1, 1, 0,  0, 2, 0, 0, 0,  7),  // R7 committed load
        mk(0, 0, 0, 0, 1, 0, 0, 0,  0, 2, 0, 0, 0,  8),  // R8 head not executed
        mk(1, 3, 0, 0, 0, 0, 0, 1,  0, 2, 1, 0, 0,  8),  // R8 queue still occupied
        mk(0, 0, 1, 1, 0, 1, 2, 0,  0, 2, 0, 0, 1,  6),  // R6 same-cycle exec
        mk(1, 5, 0, 0, 0, 1, 2, 0,  0, 2, 1, 0, 0,  9),  // R9 flush cycle
        mk(1, 6, 0, 0, 0, 0, 0, 0,  1, 0, 0, 0, 0,  9),  // R9 pointers reset
        mk(1, 7, 0, 0, 0, 0, 0, 1,  0, 1, 1, 0, 0, 10),  // R10 pause stall
        mk(0, 0, 1, 0, 0, 0, 0, 1,  0, 1, 1, 0, 0, 10),
        mk(0, 0, 0, 0, 1, 1, 6, 1,  0, 1, 1, 0, 0,  7),  // R7 commit+snoop
        mk(1, 8, 0, 0, 0, 0, 0, 1,  1, 1, 0, 0, 0, 10),  // R10 drained
        mk(0, 0, 1, 1, 0, 0, 0, 1,  0, 2, 1, 0, 0, 10),
        mk(0, 0, 0, 0, 0, 1, 8, 1,  0, 2, 1, 0, 1,  4),  // R4 hit, offset differs
        mk(0, 0, 0, 0, 0, 0, 0, 0,  0, 2, 1, 0, 0,  4)   // R4 single pulse
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_req, exec_req, commit_req, snoop_valid, pause;
    logic [31:0] alloc_addr, snoop_addr;
    logic [2:0]  exec_idx;
    logic        alloc_gnt, flush, dispatch_stall, full;
    logic [2:0]  alloc_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    lq_snoop_guard uut (
        .clk            (clk),
        .rst            (rst),
        .alloc_req      (alloc_req),
        .alloc_addr     (alloc_addr),
        .alloc_gnt      (alloc_gnt),
        .alloc_idx      (alloc_idx),
        .exec_req       (exec_req),
        .exec_idx       (exec_idx),
        .commit_req     (commit_req),
        .snoop_valid    (snoop_valid),
        .snoop_addr     (snoop_addr),
        .pause          (pause),
        .flush          (flush),
        .dispatch_stall (dispatch_stall),
        .full           (full)
    );

    function automatic logic [31:0] a_of(input logic [3:0] ln);
        return {22'h0, ln, 6'h04};
    endfunction
    function automatic logic [31:0] s_of(input logic [3:0] ln);
        return {22'h0, ln, 6'h3C};
    endfunction

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_req = 0; alloc_addr = '0; exec_req = 0; exec_idx = '0;
        commit_req = 0; snoop_valid = 0; snoop_addr = '0; pause = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic pend;
        logic pend_exp;
        int   pend_r;
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("reset flush", 1, flush, 0);
        chk("reset full", 1, full, 0);
        chk("reset stall", 1, dispatch_stall, 0);
        chk("reset idx", 1, alloc_idx, 0);
        chk("reset gnt", 1, alloc_gnt, 0);
        pause = 1; #1;
        chk("reset stall under pause", 1, dispatch_stall, 0);
        pause = 0;

        pend = 0; pend_exp = 0; pend_r = 0;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            if (pend) chk("flush", pend_r, flush, pend_exp);
            alloc_req   = TBL[k].al;
            alloc_addr  = a_of(TBL[k].aline);
            exec_req    = TBL[k].ex;
            exec_idx    = TBL[k].eidx;
            commit_req  = TBL[k].cm;
            snoop_valid = TBL[k].sn;
            snoop_addr  = s_of(TBL[k].sline);
            pause       = TBL[k].pz;
            #1;
            chk($sformatf("row%0d gnt", k),   TBL[k].rid, alloc_gnt,      TBL[k].e_gnt);
            chk($sformatf("row%0d idx", k),   TBL[k].rid, alloc_idx,      TBL[k].e_idx);
            chk($sformatf("row%0d stall", k), TBL[k].rid, dispatch_stall, TBL[k].e_stall);
            chk($sformatf("row%0d full", k),  TBL[k].rid, full,           TBL[k].e_full);
            pend = 1; pend_exp = TBL[k].e_flush; pend_r = TBL[k].rid;
        end
        @(negedge clk);
        idle();
        chk("flush after table", pend_r, flush, pend_exp);
        #1;
        chk("queue cleared idx", 9, alloc_idx, 0);   // R9

        // R2/R3 fill and wrap
        for (int i = 0; i < 8; i++) begin
            alloc_req = 1; alloc_addr = a_of(4'(i)); #1;
            chk("fill gnt", 2, alloc_gnt, 1);
            chk("fill idx", 2, alloc_idx, i);
            @(negedge clk);
        end
        alloc_addr = a_of(4'd9); #1;
        chk("full flag", 3, full, 1);         // R3
        chk("full refuse", 3, alloc_gnt, 0);  // R3
        chk("wrapped idx", 2, alloc_idx, 0);  // R2
        @(negedge clk);
        idle(); exec_req = 1; exec_idx = 3'd0;
        @(negedge clk);
        idle(); commit_req = 1;
        @(negedge clk);
        idle(); #1;
        chk("commit frees slot", 8, full, 0);  // R8
        alloc_req = 1; alloc_addr = a_of(4'd9); #1;
        chk("realloc gnt", 2, alloc_gnt, 1);
        chk("realloc idx", 2, alloc_idx, 0);
        @(negedge clk);
        idle(); #1;
        chk("refilled", 3, full, 1);
        snoop_valid = 1; snoop_addr = s_of(4'd3);  // slot 3 not executed
        @(negedge clk);
        idle();
        chk("unexecuted no flush", 5, flush, 0);   // R5
        exec_req = 1; exec_idx = 3'd3;
        @(negedge clk);
        idle(); snoop_valid = 1; snoop_addr = s_of(4'd3);
        @(negedge clk);
        idle();
        chk("full queue hit", 4, flush, 1);        // R4
        @(negedge clk);
        #1;
        chk("pulse ends", 4, flush, 0);            // R4
        chk("cleared full", 9, full, 0);           // R9
        chk("cleared idx", 9, alloc_idx, 0);       // R9
        finish_run();
    end

endmodule